// File: doc/BRIEF.md
# Dual-Clock Line Ring with 2x Nearest-Neighbour Upscaler

This block moves an 8-bit grayscale image from a camera pixel clock into a display pixel clock without a frame buffer. The camera side delivers a valid-qualified pixel stream with line-start and frame-start strobes. Complete lines are kept in a small ring of line slots inside a dual-port memory. The write port runs on the camera clock and the read port runs on the display clock.

The display side supplies its raster coordinates and a data-enable. The block halves both coordinates to find the source pixel, so every source pixel fills a 2x2 patch of a raster twice the source size. It drives the upper four bits of the stored gray value onto red, green and blue. A per-slot tag names the source line each slot holds, and the display side reads a line only when the tag it has received proves the line is complete and belongs to the current frame. In every other case it shows black.

Top module: `line_ring_upscaler`

## Requirements
- R1: For display coordinates (x, y), the pixel shown is source column x>>1 of source row y>>1, so the four positions (2c..2c+1, 2r..2r+1) all show source pixel (c, r).
- R2: disp_r, disp_g and disp_b all equal bits [7:4] of the stored gray value. They reflect the coordinates and enable presented two display clocks earlier.
- R3: When disp_de is low, all three colour outputs are 0.
- R4: Coordinates with x >= 2*SRC_W or y >= 2*SRC_H give 0 on all outputs.
- R5: A source row that has not been completely written since the last frame start reads as 0. This includes every row after reset.
- R6: A camera frame-start strobe invalidates every stored line. Afterwards all rows read as 0 until they are written again, and row counting restarts at 0.
- R7: The ring has SLOTS line slots, and row r lives in slot r mod SLOTS. Completing row r+SLOTS replaces row r, which then reads as 0 while the newer row reads back correctly.
- R8: Once the first pixel of a new line is accepted into a slot, the row that slot held reads as 0. The new row also reads as 0 until its last pixel (column SRC_W-1) is accepted.
- R9: A line-start strobe discards a partly received line. The following pixels fill the same row from column 0.
- R10: After SRC_H rows of a frame are complete, further pixels are ignored until the next frame start, and stored rows are not overwritten.
- R11: A cycle carrying a line-start or frame-start strobe accepts no pixel, even when cam_valid is high. Frame start takes priority over line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cam_clk | input | 1 | Camera pixel clock |
| cam_rst_n | input | 1 | Active-low reset, camera domain |
| cam_valid | input | 1 | cam_pixel carries a pixel this cycle |
| cam_pixel | input | PIX_W | Gray value |
| cam_line_start | input | 1 | One-cycle strobe before a line's first pixel |
| cam_frame_start | input | 1 | One-cycle strobe before a frame's first line |
| disp_clk | input | 1 | Display pixel clock |
| disp_rst_n | input | 1 | Active-low reset, display domain |
| disp_de | input | 1 | Raster position is in the visible area |
| disp_x | input | clog2(2*SRC_W) | Raster column |
| disp_y | input | clog2(2*SRC_H) | Raster row |
| disp_r | output | CH_W | Red |
| disp_g | output | CH_W | Green |
| disp_b | output | CH_W | Blue |

## Verification
The hardest situation to reach is a display read that targets a slot while the camera side is refilling that slot or has just abandoned a line in it. A black result is correct only if the slot's tag was withdrawn and that change crossed the clock boundary. The bench reaches it by writing part of a line into the slot of an older, readable row and letting the tag transfer settle. It then probes both the old row and the new row before finishing the new line, and only after that completes the line and checks that the contents read back. Ring wrap, strobe-versus-pixel collisions and lines beyond the frame height are produced the same way, as directed camera sequences followed by display probes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int unsigned DEF_SRC_W = 320;
    localparam int unsigned DEF_SRC_H = 240;
    localparam int unsigned DEF_SLOTS = 4;
    localparam int unsigned DEF_PIX_W = 8;
    localparam int unsigned DEF_CH_W  = 4;
endpackage

// File: rtl/lsu_line_writer.sv
module lsu_line_writer #(
    parameter int unsigned SRC_W = 320,
    parameter int unsigned SRC_H = 240,
    parameter int unsigned SLOTS = 4,
    parameter int unsigned PIX_W = 8,
    localparam int unsigned COL_W  = $clog2(SRC_W),
    localparam int unsigned ROW_W  = $clog2(SRC_H + 1),
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned TAG_W  = ROW_W + 1,
    localparam int unsigned ADDR_W = $clog2(SLOTS * SRC_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  logic [PIX_W-1:0]         pixel,
    input  logic                     line_start,
    input  logic                     frame_start,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [PIX_W-1:0]         mem_data,
    output logic [SLOTS*TAG_W-1:0]   tags
);
    typedef struct packed {
        logic [COL_W-1:0]              col;
        logic [ROW_W-1:0]              row;
        logic [SLOTS-1:0][TAG_W-1:0]   tag;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [SLOT_W-1:0] wslot;

    always_comb begin
        st_d     = st_q;
        wslot    = st_q.row[SLOT_W-1:0];
        mem_we   = 1'b0;
        mem_data = pixel;
        mem_addr = ADDR_W'(wslot) * ADDR_W'(SRC_W) + ADDR_W'(st_q.col);
        if (frame_start) begin
            st_d.col = '0;
            st_d.row = '0;
            st_d.tag = '0;
        end else if (line_start) begin
            st_d.col = '0;
        end else if (valid && (st_q.row < ROW_W'(SRC_H))) begin
            mem_we = 1'b1;
            if (st_q.col == '0) begin
                st_d.tag[wslot] = '0;
            end
            if (st_q.col == COL_W'(SRC_W - 1)) begin
                st_d.tag[wslot] = {1'b1, st_q.row};
                st_d.col        = '0;
                st_d.row        = st_q.row + 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tags = st_q.tag;

    AST_COL_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.col < COL_W'(SRC_W)); // R9
    AST_ROW_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row <= ROW_W'(SRC_H)); // R10
    AST_FRAME_CLEARS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> (st_q.tag == '0)); // R6
    AST_STROBE_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || frame_start) |-> !mem_we); // R11
endmodule

// File: rtl/lsu_tag_xfer.sv
module lsu_tag_xfer #(
    parameter int unsigned W = 36
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_data,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_data
);
    typedef struct packed {
        logic [W-1:0] snap;
        logic         req;
        logic         ack_s1;
        logic         ack_s2;
    } src_state_t;

    typedef struct packed {
        logic [W-1:0] data;
        logic         req_s1;
        logic         req_s2;
        logic         seen;
    } dst_state_t;

    src_state_t s_d, s_q;
    dst_state_t d_d, d_q;

    // source domain: publish a new snapshot only when the previous one was taken
    always_comb begin
        s_d        = s_q;
        s_d.ack_s1 = d_q.seen;
        s_d.ack_s2 = s_q.ack_s1;
        if ((s_q.req == s_q.ack_s2) && (src_data != s_q.snap)) begin
            s_d.snap = src_data;
            s_d.req  = ~s_q.req;
        end
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) s_q <= '0;
        else            s_q <= s_d;
    end

    // destination domain: capture the held snapshot once the request toggle arrives
    always_comb begin
        d_d        = d_q;
        d_d.req_s1 = s_q.req;
        d_d.req_s2 = d_q.req_s1;
        if (d_q.req_s2 != d_q.seen) begin
            d_d.data = s_q.snap;
            d_d.seen = d_q.req_s2;
        end
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) d_q <= '0;
        else            d_q <= d_d;
    end

    assign dst_data = d_q.data;

    AST_SNAP_HELD_WHILE_PENDING: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (s_q.req != s_q.ack_s2) |=> $stable(s_q.snap)); // R5
endmodule

// File: rtl/lsu_dpram.sv
module lsu_dpram #(
    parameter int unsigned DEPTH = 1280,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/lsu_line_reader.sv
module lsu_line_reader #(
    parameter int unsigned SRC_W = 320,
    parameter int unsigned SRC_H = 240,
    parameter int unsigned SLOTS = 4,
    parameter int unsigned PIX_W = 8,
    parameter int unsigned CH_W  = 4,
    localparam int unsigned ROW_W  = $clog2(SRC_H + 1),
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned TAG_W  = ROW_W + 1,
    localparam int unsigned ADDR_W = $clog2(SLOTS * SRC_W),
    localparam int unsigned DX_W   = $clog2(2 * SRC_W),
    localparam int unsigned DY_W   = $clog2(2 * SRC_H)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    de,
    input  logic [DX_W-1:0]         x,
    input  logic [DY_W-1:0]         y,
    input  logic [SLOTS*TAG_W-1:0]  tags,
    output logic [ADDR_W-1:0]       mem_raddr,
    input  logic [PIX_W-1:0]        mem_rdata,
    output logic [CH_W-1:0]         r,
    output logic [CH_W-1:0]         g,
    output logic [CH_W-1:0]         b
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              hit1;
        logic              hit2;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [SLOTS-1:0][TAG_W-1:0] tag_arr;
    logic [ROW_W-1:0]  src_row;
    logic [SLOT_W-1:0] rslot;
    logic [TAG_W-1:0]  cur_tag;
    logic              in_area;
    logic [CH_W-1:0]   nib;
    logic              unused_low_bits;

    assign tag_arr = tags;

    // stage 1 registers the memory address, stage 2 lines the hit flag up with the data
    always_comb begin
        st_d     = st_q;
        src_row  = ROW_W'(y >> 1);
        rslot    = src_row[SLOT_W-1:0];
        cur_tag  = tag_arr[rslot];
        in_area  = (x < DX_W'(2 * SRC_W)) && (y < DY_W'(2 * SRC_H));
        st_d.addr = ADDR_W'(rslot) * ADDR_W'(SRC_W) + ADDR_W'(x >> 1);
        st_d.hit1 = de && in_area && cur_tag[TAG_W-1] && (cur_tag[ROW_W-1:0] == src_row);
        st_d.hit2 = st_q.hit1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_raddr = st_q.addr;
    assign nib       = st_q.hit2 ? mem_rdata[PIX_W-1 -: CH_W] : '0;
    assign r         = nib;
    assign g         = nib;
    assign b         = nib;
    assign unused_low_bits = ^mem_rdata[PIX_W-CH_W-1:0];

    AST_DE_LOW_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!de, 2) |-> ({r, g, b} == '0)); // R3
    AST_OUTSIDE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(de && (y >= DY_W'(2 * SRC_H)), 2) |-> ({r, g, b} == '0)); // R4
endmodule

// File: rtl/line_ring_upscaler.sv
module line_ring_upscaler
    import lsu_pkg::*;
#(
    parameter int unsigned SRC_W = DEF_SRC_W,
    parameter int unsigned SRC_H = DEF_SRC_H,
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned PIX_W = DEF_PIX_W,
    parameter int unsigned CH_W  = DEF_CH_W
) (
    input  logic                           cam_clk,
    input  logic                           cam_rst_n,
    input  logic                           cam_valid,
    input  logic [PIX_W-1:0]               cam_pixel,
    input  logic                           cam_line_start,
    input  logic                           cam_frame_start,
    input  logic                           disp_clk,
    input  logic                           disp_rst_n,
    input  logic                           disp_de,
    input  logic [$clog2(2*SRC_W)-1:0]     disp_x,
    input  logic [$clog2(2*SRC_H)-1:0]     disp_y,
    output logic [CH_W-1:0]                disp_r,
    output logic [CH_W-1:0]                disp_g,
    output logic [CH_W-1:0]                disp_b
);
    localparam int unsigned ROW_W  = $clog2(SRC_H + 1);
    localparam int unsigned TAG_W  = ROW_W + 1;
    localparam int unsigned DEPTH  = SLOTS * SRC_W;
    localparam int unsigned ADDR_W = $clog2(DEPTH);
    localparam int unsigned TAGS_W = SLOTS * TAG_W;

    logic              wr_we;
    logic [ADDR_W-1:0] wr_addr;
    logic [PIX_W-1:0]  wr_data;
    logic [TAGS_W-1:0] cam_tags;
    logic [TAGS_W-1:0] disp_tags;
    logic [ADDR_W-1:0] rd_addr;
    logic [PIX_W-1:0]  rd_data;

    lsu_line_writer #(.SRC_W(SRC_W), .SRC_H(SRC_H), .SLOTS(SLOTS), .PIX_W(PIX_W)) writer_i (
        .clk         (cam_clk),
        .rst_n       (cam_rst_n),
        .valid       (cam_valid),
        .pixel       (cam_pixel),
        .line_start  (cam_line_start),
        .frame_start (cam_frame_start),
        .mem_we      (wr_we),
        .mem_addr    (wr_addr),
        .mem_data    (wr_data),
        .tags        (cam_tags)
    );

    lsu_tag_xfer #(.W(TAGS_W)) xfer_i (
        .src_clk   (cam_clk),
        .src_rst_n (cam_rst_n),
        .src_data  (cam_tags),
        .dst_clk   (disp_clk),
        .dst_rst_n (disp_rst_n),
        .dst_data  (disp_tags)
    );

    lsu_dpram #(.DEPTH(DEPTH), .DW(PIX_W)) ram_i (
        .wclk  (cam_clk),
        .we    (wr_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .rclk  (disp_clk),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    lsu_line_reader #(.SRC_W(SRC_W), .SRC_H(SRC_H), .SLOTS(SLOTS), .PIX_W(PIX_W), .CH_W(CH_W)) reader_i (
        .clk       (disp_clk),
        .rst_n     (disp_rst_n),
        .de        (disp_de),
        .x         (disp_x),
        .y         (disp_y),
        .tags      (disp_tags),
        .mem_raddr (rd_addr),
        .mem_rdata (rd_data),
        .r         (disp_r),
        .g         (disp_g),
        .b         (disp_b)
    );
endmodule

// File: tb/line_ring_upscaler_tb.sv
module line_ring_upscaler_tb_top;
    localparam int SW  = 20;
    localparam int SH  = 12;
    localparam int DXW = $clog2(2*SW);
    localparam int DYW = $clog2(2*SH);

    logic cam_clk = 1'b0, disp_clk = 1'b0;
    logic cam_rst_n = 1'b0, disp_rst_n = 1'b0;
    logic cam_valid = 1'b0, cam_line_start = 1'b0, cam_frame_start = 1'b0;
    logic [7:0] cam_pixel = '0;
    logic disp_de = 1'b0;
    logic [DXW-1:0] disp_x = '0;
    logic [DYW-1:0] disp_y = '0;
    logic [3:0] disp_r, disp_g, disp_b;
    int checks = 0;
    int errors = 0;

    always #10 disp_clk = ~disp_clk;   // 50 MHz display clock
    always #15 cam_clk  = ~cam_clk;

    line_ring_upscaler #(.SRC_W(SW), .SRC_H(SH), .SLOTS(4), .PIX_W(8), .CH_W(4)) dut_i (
        .cam_clk(cam_clk), .cam_rst_n(cam_rst_n), .cam_valid(cam_valid), .cam_pixel(cam_pixel),
        .cam_line_start(cam_line_start), .cam_frame_start(cam_frame_start),
        .disp_clk(disp_clk), .disp_rst_n(disp_rst_n), .disp_de(disp_de),
        .disp_x(disp_x), .disp_y(disp_y), .disp_r(disp_r), .disp_g(disp_g), .disp_b(disp_b)
    );

    function automatic logic [7:0] pv(int row, int col, int seed);
        return 8'((row*37 + col*13 + seed*59) & 255);
    endfunction

    function automatic logic [3:0] nib(int row, int col, int seed);
        logic [7:0] v;
        v = pv(row, col, seed);
        return v[7:4];
    endfunction

    task automatic check_rgb(string req, logic [3:0] exp);
        checks++;
        if (disp_r !== exp || disp_g !== exp || disp_b !== exp) begin
            errors++;
            $display("FAIL %s: r=%0h g=%0h b=%0h expected %0h", req, disp_r, disp_g, disp_b, exp);
        end
    endtask

    task automatic probe(string req, int x, int y, logic de, logic [3:0] exp);
        @(negedge disp_clk);
        disp_x = DXW'(x); disp_y = DYW'(y); disp_de = de;
        repeat (3) @(negedge disp_clk);
        check_rgb(req, exp);
        disp_de = 1'b0;
    endtask

    task automatic settle();
        repeat (16) @(negedge disp_clk);
    endtask

    task automatic pulse_frame();
        @(negedge cam_clk); cam_frame_start = 1'b1;
        @(negedge cam_clk); cam_frame_start = 1'b0;
    endtask

    task automatic send_pixels(int row, int seed, int n);
        for (int c = 0; c < n; c++) begin
            cam_valid = 1'b1; cam_pixel = pv(row, c, seed);
            @(negedge cam_clk);
        end
        cam_valid = 1'b0;
    endtask

    task automatic send_line(int row, int seed);
        @(negedge cam_clk); cam_line_start = 1'b1;
        @(negedge cam_clk); cam_line_start = 1'b0;
        send_pixels(row, seed, SW);
    endtask

    task automatic t_reset();
        check_rgb("R3 reset output", 4'h0);
        probe("R5 nothing stored after reset", 0, 0, 1'b1, 4'h0);
    endtask

    task automatic t_basic();
        pulse_frame();
        for (int r = 0; r < 3; r++) send_line(r, 1);
        settle();
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 3; k++) begin
                int c;
                c = (k == 0) ? 0 : ((k == 1) ? 7 : SW-1);
                for (int q = 0; q < 4; q++)
                    probe("R1 R2 2x2 replication", 2*c + (q & 1), 2*r + (q >> 1), 1'b1, nib(r, c, 1));
            end
        end
        probe("R5 unwritten row", 4, 6, 1'b1, 4'h0);
        probe("R3 de low", 2, 2, 1'b0, 4'h0);
        probe("R4 x beyond raster", 2*SW, 0, 1'b1, 4'h0);
        probe("R4 y beyond raster", 0, 2*SH, 1'b1, 4'h0);
    endtask

    task automatic t_ring();
        send_line(3, 1);
        send_line(4, 1);
        settle();
        probe("R7 newer row in slot 0", 10, 8, 1'b1, nib(4, 5, 1));
        probe("R7 replaced row 0", 10, 0, 1'b1, 4'h0);
        probe("R7 row 1 kept", 10, 2, 1'b1, nib(1, 5, 1));
        probe("R7 row 3 kept", 11, 7, 1'b1, nib(3, 5, 1));
    endtask

    task automatic t_partial();
        @(negedge cam_clk); cam_line_start = 1'b1;
        @(negedge cam_clk); cam_line_start = 1'b0;
        send_pixels(5, 9, 6);
        settle();
        probe("R8 slot owner withdrawn", 4, 2, 1'b1, 4'h0);
        probe("R8 row in progress", 4, 10, 1'b1, 4'h0);
        send_line(5, 2);
        settle();
        probe("R9 restart column 0", 0, 10, 1'b1, nib(5, 0, 2));
        probe("R9 restart last column", 2*(SW-1), 11, 1'b1, nib(5, SW-1, 2));
    endtask

    task automatic t_strobe();
        @(negedge cam_clk); cam_line_start = 1'b1; cam_valid = 1'b1; cam_pixel = 8'hF0;
        @(negedge cam_clk); cam_line_start = 1'b0;
        send_pixels(6, 3, SW);
        settle();
        probe("R11 strobe pixel dropped col 0", 1, 12, 1'b1, nib(6, 0, 3));
        probe("R11 strobe pixel dropped last col", 2*SW-1, 13, 1'b1, nib(6, SW-1, 3));
    endtask

    task automatic t_frame_clear();
        pulse_frame();
        settle();
        probe("R6 row 4 cleared", 6, 8, 1'b1, 4'h0);
        probe("R6 row 5 cleared", 6, 10, 1'b1, 4'h0);
        probe("R6 row 6 cleared", 6, 12, 1'b1, 4'h0);
    endtask

    task automatic t_overflow();
        for (int r = 0; r < SH; r++) send_line(r, 4);
        send_line(SH, 7);
        settle();
        probe("R10 last row intact", 6, 2*(SH-1), 1'b1, nib(SH-1, 3, 4));
        probe("R10 slot 0 not overwritten", 6, 16, 1'b1, nib(8, 3, 4));
        probe("R6 rows restart at 0", 6, 18, 1'b1, nib(9, 3, 4));
    endtask

    initial begin
        repeat (3) @(negedge disp_clk);
        cam_rst_n = 1'b1; disp_rst_n = 1'b1;
        repeat (2) @(negedge disp_clk);
        t_reset();
        t_basic();
        t_ring();
        t_partial();
        t_strobe();
        t_frame_clear();
        t_overflow();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge disp_clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule